// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Group Stop Gate

This block passes two groups of clocks derived from one source clock and lets each group be halted by its own asynchronous, active-low halt request. The processor group (a set of processor clock copies and a set of memory clock copies, both controlled by the same request) runs at the source rate. The peripheral group (a set of peripheral clock copies) runs at the source rate divided by an even ratio. One more peripheral copy is never gated and serves the loads that must keep running.

Each request is first brought into the source clock domain through a short chain of rising-edge flops. A gate enable, updated only on the falling edge of the source clock, then opens or closes the group. For the peripheral group the enable may only change while the divided clock is low. So a halted clock always rests at logic low, and the first high phase after a restart always has its full width. A request that never reaches the synchronizer is dropped without effect on the outputs.

Top module: `clkgrp_stop_gate`

## Requirements
- R1: While `rst_n` is low, every output (processor, memory, peripheral and free peripheral clocks) is held low.
- R2: A halted group rests at logic low for as long as its halt request stays asserted (low).
- R3: Every high phase of a processor or memory clock lasts exactly half a source period. Every high phase of a peripheral clock lasts BUS_RATIO/2 source periods. No truncated high phase is ever emitted.
- R4: When the processor request falls during the low phase of the source clock, the processor clocks emit exactly one more rising edge (on the next source rising edge) and then stay low. This is a halt latency of at most one source clock.
- R5: When the processor request rises during the low phase of the source clock, the first processor rising edge comes on the second source rising edge after the request, 1.5 source periods later. This is a restart latency of at most one source clock after synchronization.
- R6: The memory clocks are controlled by the processor request and always carry the same level as the processor clocks.
- R7: After the peripheral request falls, no peripheral rising edge occurs later than 4 source periods after the request, and the peripheral clocks then stay low.
- R8: After the peripheral request rises, the first peripheral rising edge occurs within 4 source periods and is a full-width pulse.
- R9: The free peripheral clock toggles at the source rate divided by BUS_RATIO under every combination of requests. The processor request has no effect on the peripheral group, and the peripheral request has no effect on the processor group.
- R10: A halt request that is low only between two source rising edges, and is never sampled by one, is ignored: no pulse of its group is lost.
- R11: All copies inside one group carry identical levels at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n_i | input | 1 | Asynchronous active-low halt request for the processor and memory clocks |
| bus_stop_n_i | input | 1 | Asynchronous active-low halt request for the peripheral clocks |
| cpu_clk_o | output | N_CPU | Gated processor clock copies |
| mem_clk_o | output | N_MEM | Gated memory clock copies |
| bus_clk_o | output | N_BUS | Gated peripheral clock copies (source / BUS_RATIO) |
| bus_free_o | output | 1 | Ungated peripheral clock copy |

## Verification
The processor group responds on the source rising edge that samples the request, and its enable moves on the following falling edge. For this reason the bench changes requests one time unit after a falling edge. It then expects one more processor pulse on a halt and the first new pulse exactly 1.5 periods later on a restart. The peripheral group passes two sync flops and waits for a low phase of the divided clock, so its checks use a 4-period bound rather than a fixed cycle. The steady-state checks only count edges after six settling periods, over a window of whole source periods. Pulse widths and copy equality are watched for the whole run and judged at the end.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic {
        GATE_PARKED  = 1'b0,
        GATE_PASSING = 1'b1
    } gate_state_e;

    function automatic int unsigned half_ratio(input int unsigned ratio);
        return (ratio < 2) ? 1 : ratio / 2;
    endfunction

endpackage

// File: rtl/clkgrp_stop_sync.sv
module clkgrp_stop_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_n_i,
    output logic run_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = STAGES'({sync_q.chain, req_n_i});
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign run_o = sync_q.chain[LAST];

endmodule

// File: rtl/clkgrp_gate_enable.sv
module clkgrp_gate_enable
    import clkgate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n,
    input  logic run_i,
    input  logic permit_i,
    output logic pass_o
);
    typedef struct packed {
        gate_state_e st;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (permit_i) begin
            gate_d.st = run_i ? GATE_PASSING : GATE_PARKED;
        end
    end

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '{st: GATE_PARKED};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign pass_o = (gate_q.st == GATE_PASSING);

endmodule

// File: rtl/clkgrp_bus_phase.sv
module clkgrp_bus_phase
    import clkgate_pkg::*;
#(
    parameter int unsigned RATIO = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    output logic lvl_o
);
    localparam int unsigned HALF = half_ratio(RATIO);
    localparam int unsigned CW   = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(RATIO - 1);
    localparam logic [CW-1:0] CNT_HALF = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (ph_q.cnt == CNT_LAST) begin
            ph_d.cnt = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
        ph_d.lvl = (ph_d.cnt < CNT_HALF);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{cnt: CNT_LAST, lvl: 1'b0};
        end else begin
            ph_q <= ph_d;
        end
    end

    assign lvl_o = ph_q.lvl;

endmodule

// File: rtl/clkgrp_stop_gate.sv
module clkgrp_stop_gate #(
    parameter int unsigned N_CPU     = 4,
    parameter int unsigned N_MEM     = 6,
    parameter int unsigned N_BUS     = 6,
    parameter int unsigned FAST_SYNC = 1,
    parameter int unsigned BUS_SYNC  = 2,
    parameter int unsigned BUS_RATIO = 2
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             cpu_stop_n_i,
    input  logic             bus_stop_n_i,
    output logic [N_CPU-1:0] cpu_clk_o,
    output logic [N_MEM-1:0] mem_clk_o,
    output logic [N_BUS-1:0] bus_clk_o,
    output logic             bus_free_o
);
    logic cpu_run;
    logic bus_run;
    logic cpu_pass;
    logic bus_pass;
    logic bus_lvl;
    logic bus_low;

    clkgrp_stop_sync #(.STAGES(FAST_SYNC)) u_cpu_sync (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .req_n_i (cpu_stop_n_i),
        .run_o   (cpu_run)
    );

    clkgrp_stop_sync #(.STAGES(BUS_SYNC)) u_bus_sync (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .req_n_i (bus_stop_n_i),
        .run_o   (bus_run)
    );

    clkgrp_bus_phase #(.RATIO(BUS_RATIO)) u_bus_phase (
        .clk_i (clk_i),
        .rst_n (rst_n),
        .lvl_o (bus_lvl)
    );

    // The processor enable moves on every falling edge; the peripheral
    // enable only on falling edges inside a low phase of the divided clock.
    assign bus_low = ~bus_lvl;

    clkgrp_gate_enable u_cpu_gate (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .run_i    (cpu_run),
        .permit_i (1'b1),
        .pass_o   (cpu_pass)
    );

    clkgrp_gate_enable u_bus_gate (
        .clk_i    (clk_i),
        .rst_n    (rst_n),
        .run_i    (bus_run),
        .permit_i (bus_low),
        .pass_o   (bus_pass)
    );

    for (genvar g = 0; g < N_CPU; g++) begin : g_cpu
        assign cpu_clk_o[g] = clk_i & cpu_pass;
    end

    for (genvar g = 0; g < N_MEM; g++) begin : g_mem
        assign mem_clk_o[g] = clk_i & cpu_pass;
    end

    for (genvar g = 0; g < N_BUS; g++) begin : g_bus
        assign bus_clk_o[g] = bus_lvl & bus_pass;
    end

    assign bus_free_o = bus_lvl;

endmodule

// File: rtl/clkgrp_stop_gate_chk.sv
module clkgrp_stop_gate_chk
    import clkgate_pkg::*;
#(
    parameter int unsigned N_CPU     = 4,
    parameter int unsigned N_MEM     = 6,
    parameter int unsigned N_BUS     = 6,
    parameter int unsigned FAST_SYNC = 1,
    parameter int unsigned BUS_SYNC  = 2,
    parameter int unsigned BUS_RATIO = 2
) (
    input logic             clk_i,
    input logic             rst_n,
    input logic             cpu_stop_n_i,
    input logic             bus_stop_n_i,
    input logic [N_CPU-1:0] cpu_clk_o,
    input logic [N_MEM-1:0] mem_clk_o,
    input logic [N_BUS-1:0] bus_clk_o,
    input logic             cpu_pass,
    input logic             bus_pass,
    input logic             bus_lvl
);
    localparam int unsigned BUS_HALF = half_ratio(BUS_RATIO);
    localparam logic [4:0]  CPU_LIM  = 5'(FAST_SYNC);
    localparam logic [4:0]  BUS_LIM  = 5'(BUS_SYNC + BUS_HALF);

    logic [4:0] cpu_lo_cnt, cpu_hi_cnt, bus_lo_cnt, bus_hi_cnt;
    logic       cpu_pass_at_rise, bus_pass_at_rise;

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
            cpu_lo_cnt       <= '0;
            cpu_hi_cnt       <= '0;
            bus_lo_cnt       <= '0;
            bus_hi_cnt       <= '0;
            cpu_pass_at_rise <= 1'b0;
            bus_pass_at_rise <= 1'b0;
        end else begin
            cpu_pass_at_rise <= cpu_pass;
            bus_pass_at_rise <= bus_pass;
            if (cpu_stop_n_i) begin
                cpu_lo_cnt <= '0;
                cpu_hi_cnt <= (cpu_hi_cnt == 5'd31) ? cpu_hi_cnt : cpu_hi_cnt + 1'b1;
            end else begin
                cpu_hi_cnt <= '0;
                cpu_lo_cnt <= (cpu_lo_cnt == 5'd31) ? cpu_lo_cnt : cpu_lo_cnt + 1'b1;
            end
            if (bus_stop_n_i) begin
                bus_lo_cnt <= '0;
                bus_hi_cnt <= (bus_hi_cnt == 5'd31) ? bus_hi_cnt : bus_hi_cnt + 1'b1;
            end else begin
                bus_hi_cnt <= '0;
                bus_lo_cnt <= (bus_lo_cnt == 5'd31) ? bus_lo_cnt : bus_lo_cnt + 1'b1;
            end
        end
    end

    AST_CPU_LOW_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (cpu_clk_o == '0) && (mem_clk_o == '0)); // R2

    AST_BUS_PARKED_LOW: assert property (@(negedge clk_i) disable iff (!rst_n)
        !bus_pass |-> (bus_clk_o == '0)); // R2

    AST_CPU_PASS_HELD: assert property (@(negedge clk_i) disable iff (!rst_n)
        cpu_pass == cpu_pass_at_rise); // R3

    AST_BUS_PASS_HELD: assert property (@(posedge clk_i) disable iff (!rst_n)
        bus_lvl |-> (bus_pass == bus_pass_at_rise)); // R3

    AST_CPU_STOP_BOUND: assert property (@(negedge clk_i) disable iff (!rst_n)
        (cpu_lo_cnt > CPU_LIM) |-> (cpu_clk_o == '0)); // R4

    AST_CPU_START_BOUND: assert property (@(negedge clk_i) disable iff (!rst_n)
        (cpu_hi_cnt > CPU_LIM) |-> (cpu_clk_o == '1)); // R5

    AST_BUS_STOP_BOUND: assert property (@(negedge clk_i) disable iff (!rst_n)
        (bus_lo_cnt > BUS_LIM) |-> (bus_clk_o == '0)); // R7

    AST_BUS_START_BOUND: assert property (@(negedge clk_i) disable iff (!rst_n)
        ((bus_hi_cnt > BUS_LIM) && bus_lvl) |-> (bus_clk_o == '1)); // R8

    AST_GROUP_COPIES: assert property (@(negedge clk_i) disable iff (!rst_n)
        (mem_clk_o == {N_MEM{cpu_clk_o[0]}}) && (cpu_clk_o == {N_CPU{cpu_clk_o[0]}})
        && (bus_clk_o == {N_BUS{bus_clk_o[0]}})); // R11

endmodule

bind clkgrp_stop_gate clkgrp_stop_gate_chk #(
    .N_CPU     (N_CPU),
    .N_MEM     (N_MEM),
    .N_BUS     (N_BUS),
    .FAST_SYNC (FAST_SYNC),
    .BUS_SYNC  (BUS_SYNC),
    .BUS_RATIO (BUS_RATIO)
) u_chk (
    .clk_i        (clk_i),
    .rst_n        (rst_n),
    .cpu_stop_n_i (cpu_stop_n_i),
    .bus_stop_n_i (bus_stop_n_i),
    .cpu_clk_o    (cpu_clk_o),
    .mem_clk_o    (mem_clk_o),
    .bus_clk_o    (bus_clk_o),
    .cpu_pass     (cpu_pass),
    .bus_pass     (bus_pass),
    .bus_lvl      (bus_lvl)
);

// File: tb/clkgrp_stop_gate_tb.sv
`timescale 1ns/1ps
module clkgrp_stop_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CPU = 4;
    localparam int N_MEM = 6;
    localparam int N_BUS = 6;
    localparam int BUS_RATIO = 2;
    localparam int NV = 8;
    // {cpu_stop_n, bus_stop_n, cpu expected running, bus expected running}
    localparam logic [3:0] VEC [NV] = '{4'b1111, 4'b0101, 4'b1010, 4'b0000,
                                        4'b1111, 4'b0000, 4'b0101, 4'b1111};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1;
    logic bus_stop_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk;
    logic [N_MEM-1:0] mem_clk;
    logic [N_BUS-1:0] bus_clk;
    logic bus_free;

    int checks = 0;
    int errors = 0;
    int cpu_rises = 0, bus_rises = 0, free_rises = 0;
    int cpu_width_err = 0, mem_width_err = 0, bus_width_err = 0, copy_err = 0;
    realtime t_cpu_r = 0, t_mem_r = 0, t_bus_r = 0;
    bit done = 0;

    clkgrp_stop_gate u_dut (
        .clk_i        (clk),
        .rst_n        (rst_n),
        .cpu_stop_n_i (cpu_stop_n),
        .bus_stop_n_i (bus_stop_n),
        .cpu_clk_o    (cpu_clk),
        .mem_clk_o    (mem_clk),
        .bus_clk_o    (bus_clk),
        .bus_free_o   (bus_free)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge cpu_clk[0]) begin cpu_rises++; t_cpu_r = $realtime; end
    always @(negedge cpu_clk[0]) if ($realtime - t_cpu_r != CLK_PERIOD/2.0) cpu_width_err++;
    always @(posedge mem_clk[0]) t_mem_r = $realtime;
    always @(negedge mem_clk[0]) if ($realtime - t_mem_r != CLK_PERIOD/2.0) mem_width_err++;
    always @(posedge bus_clk[0]) begin bus_rises++; t_bus_r = $realtime; end
    always @(negedge bus_clk[0])
        if ($realtime - t_bus_r != real'(CLK_PERIOD * BUS_RATIO / 2)) bus_width_err++;
    always @(posedge bus_free) free_rises++;

    always begin
        @(clk);
        #1;
        if (cpu_clk != {N_CPU{cpu_clk[0]}} || mem_clk != {N_MEM{cpu_clk[0]}}
            || bus_clk != {N_BUS{bus_clk[0]}}) copy_err++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic after_fall();
        @(negedge clk);
        #1;
    endtask

    task automatic window(input int periods, output int dc, output int db, output int df);
        int c0, b0, f0;
        c0 = cpu_rises; b0 = bus_rises; f0 = free_rises;
        #(periods * CLK_PERIOD);
        dc = cpu_rises - c0; db = bus_rises - b0; df = free_rises - f0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dc, db, df;
        realtime t0;
        // R1: reset state with clock running
        for (int k = 0; k < 3; k++) begin
            after_fall();
            check({cpu_clk, mem_clk, bus_clk, bus_free} == '0, "R1", "outputs in reset",
                  {cpu_clk, mem_clk, bus_clk, bus_free}, 0);
            @(posedge clk); #1;
            check({cpu_clk, mem_clk, bus_clk, bus_free} == '0, "R1", "outputs in reset high",
                  {cpu_clk, mem_clk, bus_clk, bus_free}, 0);
        end
        after_fall();
        rst_n = 1'b1;

        // Table walk: R2, R4, R5, R7, R8, R9
        for (int v = 0; v < NV; v++) begin
            after_fall();
            cpu_stop_n = VEC[v][3];
            bus_stop_n = VEC[v][2];
            #(6 * CLK_PERIOD);
            window(8, dc, db, df);
            check(dc == (VEC[v][1] ? 8 : 0), "R4/R5 R9", "cpu rises in window", dc, VEC[v][1] ? 8 : 0);
            check(db == (VEC[v][0] ? 4 : 0), "R7/R8 R9", "bus rises in window", db, VEC[v][0] ? 4 : 0);
            check(df == 4, "R9", "free bus rises", df, 4);
            after_fall();
            if (!VEC[v][1]) check(cpu_clk == '0 && mem_clk == '0, "R2", "cpu parked low", cpu_clk, 0);
            if (!VEC[v][0]) check(bus_clk == '0, "R2", "bus parked low", bus_clk, 0);
        end

        // R4: exactly one more cpu pulse after halt request
        after_fall();
        cpu_stop_n = 1'b0;
        window(6, dc, db, df);
        check(dc == 1, "R4", "cpu rises after halt", dc, 1);
        check(db == 3, "R9", "bus unaffected by cpu halt", db, 3);

        // R5: first cpu pulse 1.5 periods after restart request
        after_fall();
        cpu_stop_n = 1'b1;
        t0 = $realtime;
        @(posedge cpu_clk[0]);
        check(longint'($realtime - t0) == (3 * CLK_PERIOD / 2 - 1), "R5", "cpu restart delay ns",
              longint'($realtime - t0), 3 * CLK_PERIOD / 2 - 1);
        #(4 * CLK_PERIOD);

        // R7: bus halt bound
        after_fall();
        bus_stop_n = 1'b0;
        #(4 * CLK_PERIOD);
        window(8, dc, db, df);
        check(db == 0, "R7", "bus rises later than 4 periods", db, 0);
        check(dc == 8, "R9", "cpu unaffected by bus halt", dc, 8);
        check(bus_clk == '0, "R7", "bus held low", bus_clk, 0);

        // R8: bus restart bound
        after_fall();
        bus_stop_n = 1'b1;
        t0 = $realtime;
        @(posedge bus_clk[0]);
        check(($realtime - t0) <= 4.0 * CLK_PERIOD, "R8", "bus restart delay ns",
              longint'($realtime - t0), 4 * CLK_PERIOD);
        #(4 * CLK_PERIOD);

        // R10: unsampled request pulses are ignored
        @(posedge clk); #1;
        cpu_stop_n = 1'b0;
        bus_stop_n = 1'b0;
        #2;
        cpu_stop_n = 1'b1;
        bus_stop_n = 1'b1;
        window(8, dc, db, df);
        check(dc == 8, "R10", "cpu rises after short request", dc, 8);
        check(db == 4, "R10", "bus rises after short request", db, 4);

        // R3, R6, R11: whole-run monitors
        check(cpu_width_err == 0, "R3", "cpu short high phases", cpu_width_err, 0);
        check(bus_width_err == 0, "R3", "bus short high phases", bus_width_err, 0);
        check(mem_width_err == 0, "R6", "mem short high phases", mem_width_err, 0);
        check(copy_err == 0, "R11", "group copy mismatches", copy_err, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule